// File: doc/BRIEF.md
# Pseudo-Random-Counted Raster Timing Generator

This block produces horizontal sync, vertical sync and a display-enable signal for a raster display. Its two position counters are not binary. Each is a 16-bit maximal-length linear feedback shift register (LFSR), so a counter step needs only one XOR level. Every boundary is loaded as the LFSR state the counter holds at that position. An equality comparator detects each boundary, so the block has no magnitude comparators and no carry chains.

Before the block sees a timing value, software converts the binary count into an LFSR state. It does this by stepping the same polynomial from the all-ones seed. The block advances only on cycles where the pixel clock enable is high. A blanking code selects one of three behaviours: normal output, blanked output with the counters still running, or a latched power-down state. The power-down state lasts until a new configuration is loaded. Two strobes mark position zero of each line and of each frame.

Top module: `lfsr_raster_timer`

## Requirements
- R1: A synchronous reset leaves both counters at 16'hFFFF and all sync and enable outputs inactive. Both strobes are high because the position is zero. The power-down latch is clear.
- R2: A counter step shifts the state left by one bit. The new bit 0 is the XOR of old bits 15, 4, 2 and 1. On cycles with `pix_en` low, both counters and all outputs hold.
- R3: When the horizontal counter equals `h_end`, the next enabled step reloads it with 16'hFFFF. Programming `h_end` with the state for count N gives a line of N+1 positions. `line_start_o` is high exactly while the horizontal position is zero.
- R4: The vertical counter advances once per line wrap. If its stepped value would equal `v_end`, it reloads 16'hFFFF instead. Programming the state for count N gives a frame of N lines. `frame_start_o` is high while both positions are zero.
- R5: Sync and window flags are updated on each enabled step from the position being entered. A match on the stop value clears the flag. Otherwise a match on the start value sets it. `hsync_o` is therefore active for positions from start up to, but not including, stop.
- R6: `vsync_o` follows the same rule using the vertical position. Vertical flags are evaluated on every enabled step, so after a reset or load they take effect from the first enabled step.
- R7: `de_o` is active only when both the horizontal and vertical display windows are open.
- R8: When a window's start and stop values are equal, the stop match wins and the window never opens.
- R9: Blank code 8'h00 gives normal outputs. Any other code except 8'h07 forces the syncs and `de_o` inactive while both counters keep running.
- R10: Sampling blank code 8'h07 sets a power-down latch. While the latch is set, both counters are held at 16'hFFFF, all outputs are inactive, and both strobes are low. A later change of blank code does not clear the latch.
- R11: A `cfg_load` pulse clears the power-down latch. It also restarts both counters from 16'hFFFF and clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel step enable |
| cfg_load | input | 1 | Restart pulse after new timing is programmed |
| blank_mode | input | 8 | Blanking code |
| h_end | input | 16 | Horizontal end-count state |
| h_sync_on | input | 16 | Horizontal sync start state |
| h_sync_off | input | 16 | Horizontal sync stop state |
| h_win_on | input | 16 | Horizontal display window start state |
| h_win_off | input | 16 | Horizontal display window stop state |
| v_end | input | 16 | Vertical end-count state |
| v_sync_on | input | 16 | Vertical sync start state |
| v_sync_off | input | 16 | Vertical sync stop state |
| v_win_on | input | 16 | Vertical display window start state |
| v_win_off | input | 16 | Vertical display window stop state |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| line_start_o | output | 1 | High at horizontal position zero |
| frame_start_o | output | 1 | High at horizontal and vertical position zero |

## Verification
The bench programs timings by stepping the polynomial itself from the all-ones seed. It then tracks binary positions and compares every output on every cycle. This exposes a wrong feedback tap, since lines would have the wrong length and every window would shift. It also exposes an off-by-one in the vertical wrap, since frames would have an extra line. Randomly gated `pix_en` shows up a counter that moves without enable. Windows with equal start and stop would open for a whole line if set took priority over clear. The bench also holds the power-down code for one cycle and then releases it to 8'h00. A latch that was not sticky would bring the syncs back without a load.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   localparam int unsigned POS_W  = 16;
   localparam int unsigned CODE_W = 8;

   typedef logic [POS_W-1:0] pos_t;

   localparam pos_t SEED = '1;

   localparam logic [CODE_W-1:0] CODE_RUN  = 8'h00;
   localparam logic [CODE_W-1:0] CODE_DOWN = 8'h07;

   function automatic pos_t lfsr_next(input pos_t s);
      return {s[POS_W-2:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
   endfunction
endpackage

// File: rtl/vtg_lfsr_axis.sv
module vtg_lfsr_axis
   import vtg_pkg::*;
#(
   parameter bit MATCH_STEPPED = 1'b0
) (
   input  logic clk,
   input  logic clear,
   input  logic adv,
   input  pos_t end_val,
   output pos_t cnt_q,
   output pos_t cnt_n,
   output logic wrap
);
   pos_t cnt_r;
   pos_t stepped;
   logic hit;

   assign stepped = lfsr_next(cnt_r);

   generate
      if (MATCH_STEPPED) begin : g_match_next
         assign hit = (stepped == end_val);
      end else begin : g_match_now
         assign hit = (cnt_r == end_val);
      end
   endgenerate

   assign wrap = adv & hit & ~clear;

   always_comb begin
      if (clear)      cnt_n = SEED;
      else if (!adv)  cnt_n = cnt_r;
      else if (hit)   cnt_n = SEED;
      else            cnt_n = stepped;
   end

   always_ff @(posedge clk) begin
      cnt_r <= cnt_n;
   end

   assign cnt_q = cnt_r;
endmodule

// File: rtl/vtg_window.sv
module vtg_window
   import vtg_pkg::*;
(
   input  logic clk,
   input  logic clear,
   input  logic upd,
   input  pos_t pos_n,
   input  pos_t on_val,
   input  pos_t off_val,
   output logic active
);
   always_ff @(posedge clk) begin
      if (clear) begin
         active <= 1'b0;
      end else if (upd) begin
         if (pos_n == off_val)      active <= 1'b0;
         else if (pos_n == on_val)  active <= 1'b1;
      end
   end
endmodule

// File: rtl/lfsr_raster_timer.sv
module lfsr_raster_timer
   import vtg_pkg::*;
#(
   parameter bit SYNC_ACT_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pix_en,
   input  logic              cfg_load,
   input  logic [CODE_W-1:0] blank_mode,
   input  logic [POS_W-1:0]  h_end,
   input  logic [POS_W-1:0]  h_sync_on,
   input  logic [POS_W-1:0]  h_sync_off,
   input  logic [POS_W-1:0]  h_win_on,
   input  logic [POS_W-1:0]  h_win_off,
   input  logic [POS_W-1:0]  v_end,
   input  logic [POS_W-1:0]  v_sync_on,
   input  logic [POS_W-1:0]  v_sync_off,
   input  logic [POS_W-1:0]  v_win_on,
   input  logic [POS_W-1:0]  v_win_off,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic              line_start_o,
   output logic              frame_start_o
);
   localparam int unsigned N_FLAGS = 4;
   localparam int unsigned F_HS = 0;
   localparam int unsigned F_HW = 1;
   localparam int unsigned F_VS = 2;
   localparam int unsigned F_VW = 3;

   logic pd_q, pd_n, hold, step;
   pos_t h_cnt, h_nxt, v_cnt, v_nxt;
   logic h_wrap, v_wrap;
   logic [N_FLAGS-1:0] flag;
   pos_t flag_pos [N_FLAGS];
   pos_t flag_on  [N_FLAGS];
   pos_t flag_off [N_FLAGS];
   logic normal, hs_lvl, vs_lvl;

   // power-down latch: set by the down code, cleared only by a load
   assign pd_n = ~cfg_load & (pd_q | (blank_mode == CODE_DOWN));
   assign hold = rst | cfg_load | pd_n;
   assign step = pix_en & ~hold;

   always_ff @(posedge clk) begin
      if (rst) pd_q <= 1'b0;
      else     pd_q <= pd_n;
   end

   vtg_lfsr_axis #(.MATCH_STEPPED(1'b0)) u_h_axis (
      .clk     (clk),
      .clear   (hold),
      .adv     (step),
      .end_val (h_end),
      .cnt_q   (h_cnt),
      .cnt_n   (h_nxt),
      .wrap    (h_wrap)
   );

   vtg_lfsr_axis #(.MATCH_STEPPED(1'b1)) u_v_axis (
      .clk     (clk),
      .clear   (hold),
      .adv     (h_wrap),
      .end_val (v_end),
      .cnt_q   (v_cnt),
      .cnt_n   (v_nxt),
      .wrap    (v_wrap)
   );

   assign flag_pos[F_HS] = h_nxt;  assign flag_on[F_HS] = h_sync_on;  assign flag_off[F_HS] = h_sync_off;
   assign flag_pos[F_HW] = h_nxt;  assign flag_on[F_HW] = h_win_on;   assign flag_off[F_HW] = h_win_off;
   assign flag_pos[F_VS] = v_nxt;  assign flag_on[F_VS] = v_sync_on;  assign flag_off[F_VS] = v_sync_off;
   assign flag_pos[F_VW] = v_nxt;  assign flag_on[F_VW] = v_win_on;   assign flag_off[F_VW] = v_win_off;

   generate
      for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_flag
         vtg_window u_win (
            .clk     (clk),
            .clear   (hold),
            .upd     (step),
            .pos_n   (flag_pos[gi]),
            .on_val  (flag_on[gi]),
            .off_val (flag_off[gi]),
            .active  (flag[gi])
         );
      end
   endgenerate

   assign normal = (blank_mode == CODE_RUN) & ~pd_q;
   assign hs_lvl = flag[F_HS] & normal;
   assign vs_lvl = flag[F_VS] & normal;
   assign de_o   = flag[F_HW] & flag[F_VW] & normal;

   generate
      if (SYNC_ACT_LOW) begin : g_sync_low
         assign hsync_o = ~hs_lvl;
         assign vsync_o = ~vs_lvl;
      end else begin : g_sync_high
         assign hsync_o = hs_lvl;
         assign vsync_o = vs_lvl;
      end
   endgenerate

   assign line_start_o  = ~pd_q & (h_cnt == SEED);
   assign frame_start_o = line_start_o & (v_cnt == SEED);

   logic unused_ok;
   assign unused_ok = v_wrap;
endmodule

// File: rtl/lfsr_raster_timer_chk.sv
module lfsr_raster_timer_chk
   import vtg_pkg::*;
#(
   parameter bit SYNC_ACT_LOW = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              pix_en,
   input logic              cfg_load,
   input logic [CODE_W-1:0] blank_mode,
   input pos_t              h_end,
   input pos_t              h_cnt,
   input pos_t              v_cnt,
   input logic              pd_q,
   input logic              hsync_o,
   input logic              de_o,
   input logic              line_start_o
);
   logic runs;
   assign runs = ~cfg_load & ~pd_q & (blank_mode != CODE_DOWN);

   AST_RESET_SEED: assert property (@(posedge clk)
      rst |=> (h_cnt == SEED) && (v_cnt == SEED) && !de_o && !pd_q); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (runs && !pix_en) |=> $stable(h_cnt) && $stable(v_cnt)); // R2

   AST_LINE_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (runs && pix_en && h_cnt == h_end) |=> (h_cnt == SEED)); // R3

   AST_MIDLINE_V_STILL: assert property (@(posedge clk) disable iff (rst)
      (runs && pix_en && h_cnt != h_end) |=> $stable(v_cnt)); // R4

   AST_BLANK_NO_DE: assert property (@(posedge clk) disable iff (rst)
      (blank_mode != CODE_RUN) |-> !de_o); // R9

   AST_DOWN_DARK: assert property (@(posedge clk) disable iff (rst)
      pd_q |-> (!de_o && !line_start_o && hsync_o == SYNC_ACT_LOW)); // R10

   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
      cfg_load |=> (h_cnt == SEED) && (v_cnt == SEED) && !pd_q); // R11
endmodule

bind lfsr_raster_timer lfsr_raster_timer_chk #(.SYNC_ACT_LOW(SYNC_ACT_LOW)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .pix_en       (pix_en),
   .cfg_load     (cfg_load),
   .blank_mode   (blank_mode),
   .h_end        (h_end),
   .h_cnt        (h_cnt),
   .v_cnt        (v_cnt),
   .pd_q         (pd_q),
   .hsync_o      (hsync_o),
   .de_o         (de_o),
   .line_start_o (line_start_o)
);

// File: tb/lfsr_raster_timer_bench.sv
module lfsr_raster_timer_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pix_en = 1'b0;
   logic cfg_load = 1'b0;
   logic [7:0] blank_mode = 8'h00;
   logic [15:0] h_end, h_sync_on, h_sync_off, h_win_on, h_win_off;
   logic [15:0] v_end, v_sync_on, v_sync_off, v_win_on, v_win_off;
   logic hsync_o, vsync_o, de_o, line_start_o, frame_start_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   lfsr_raster_timer u_lfsr_raster_timer (
      .clk(clk), .rst(rst), .pix_en(pix_en), .cfg_load(cfg_load),
      .blank_mode(blank_mode),
      .h_end(h_end), .h_sync_on(h_sync_on), .h_sync_off(h_sync_off),
      .h_win_on(h_win_on), .h_win_off(h_win_off),
      .v_end(v_end), .v_sync_on(v_sync_on), .v_sync_off(v_sync_off),
      .v_win_on(v_win_on), .v_win_off(v_win_off),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
      .line_start_o(line_start_o), .frame_start_o(frame_start_o)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // binary reference timing
   int htot, hsw, hds, hact, vtot, vsw, vds, vact;
   // reference position state
   int m_h, m_v;
   bit m_pd, m_valid;

   function automatic logic [15:0] lfsr_of(input int n);
      logic [15:0] s = 16'hFFFF;
      for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
      return s;
   endfunction

   task automatic chk(input string dflt, input string ph, input string nm,
                      input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b (h=%0d v=%0d)",
                  (ph != "") ? ph : dflt, nm, act, exp, m_h, m_v);
      end
   endtask

   task automatic compare(input string ph);
      bit nrm, e_hs, e_vs, e_de, e_ls, e_fs;
      nrm  = (blank_mode == 8'h00) && !m_pd;
      e_hs = nrm && m_h >= 1 && m_h < hsw + 1;
      e_vs = nrm && m_valid && m_v < vsw;
      e_de = nrm && m_valid && m_h >= hds && m_h < hds + hact
                            && m_v >= vds && m_v < vds + vact;
      e_ls = !m_pd && m_h == 0;
      e_fs = e_ls && m_v == 0;
      chk("R5", ph, "hsync", hsync_o, e_hs);
      chk("R6", ph, "vsync", vsync_o, e_vs);
      chk("R7", ph, "de", de_o, e_de);
      chk("R3", ph, "line_start", line_start_o, e_ls);
      chk("R4", ph, "frame_start", frame_start_o, e_fs);
   endtask

   // drive one cycle's inputs, advance the reference, compare at the next negedge
   task automatic cycle(input bit pe, input bit ld, input logic [7:0] bm, input string ph);
      bit pd_n;
      pix_en = pe; cfg_load = ld; blank_mode = bm;
      pd_n = !ld && (m_pd || bm == 8'h07);
      if (ld || pd_n) begin
         m_h = 0; m_v = 0; m_valid = 1'b0;
      end else if (pe) begin
         m_valid = 1'b1;
         if (m_h == htot - 1) begin
            m_h = 0;
            m_v = (m_v + 1 == vtot) ? 0 : m_v + 1;
         end else begin
            m_h = m_h + 1;
         end
      end
      m_pd = pd_n;
      @(negedge clk);
      compare(ph);
   endtask

   task automatic set_timing(input int a_htot, input int a_hsw, input int a_hds, input int a_hact,
                             input int a_vtot, input int a_vsw, input int a_vds, input int a_vact);
      htot = a_htot; hsw = a_hsw; hds = a_hds; hact = a_hact;
      vtot = a_vtot; vsw = a_vsw; vds = a_vds; vact = a_vact;
      h_end      = lfsr_of(htot - 1);
      h_sync_on  = lfsr_of(1);
      h_sync_off = lfsr_of(hsw + 1);
      h_win_on   = lfsr_of(hds);
      h_win_off  = lfsr_of(hds + hact);
      v_end      = lfsr_of(vtot);
      v_sync_on  = lfsr_of(0);
      v_sync_off = lfsr_of(vsw);
      v_win_on   = lfsr_of(vds);
      v_win_off  = lfsr_of(vds + vact);
   endtask

   task automatic run(input int n, input int pe_pct, input logic [7:0] bm, input string ph);
      for (int i = 0; i < n; i++)
         cycle(($urandom % 100) < pe_pct, 1'b0, bm, ph);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      set_timing(24, 3, 6, 12, 8, 2, 3, 4);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      m_h = 0; m_v = 0; m_pd = 1'b0; m_valid = 1'b0;
      compare("R1");                                   // reset state

      run(2 * 24 * 8 + 5, 100, 8'h00, "");             // R3..R7 full speed
      run(500, 60, 8'h00, "R2");                       // gated steps hold

      run(120, 90, 8'h01, "R9");                       // blank, counters run
      run(40, 90, 8'h05, "R9");
      run(60, 90, 8'h00, "R9");

      cycle(1'b1, 1'b0, 8'h07, "R10");                 // power-down sampled
      run(60, 100, 8'h00, "R10");                      // stays down
      cycle(1'b1, 1'b1, 8'h00, "R11");                 // load restarts
      run(24 * 8 + 30, 100, 8'h00, "R11");

      set_timing(20, 2, 5, 0, 8, 2, 3, 0);             // equal on/off windows
      cycle(1'b0, 1'b1, 8'h00, "R8");
      run(2 * 20 * 8, 100, 8'h00, "R8");

      for (int k = 0; k < 5; k++) begin
         int t_h, t_s, t_d, t_v, t_vs, t_vd;
         t_h  = $urandom_range(40, 16);
         t_s  = $urandom_range(3, 1);
         t_d  = $urandom_range(t_h / 2, t_s + 2);
         t_v  = $urandom_range(14, 6);
         t_vs = $urandom_range(2, 1);
         t_vd = $urandom_range(t_v / 2, t_vs + 1);
         set_timing(t_h, t_s, t_d, $urandom_range(t_h - 1 - t_d, 1),
                    t_v, t_vs, t_vd, $urandom_range(t_v - 1 - t_vd, 1));
         cycle(1'b0, 1'b1, 8'h00, "R11");
         run(2 * t_h * t_v + 20, 80, 8'h00, "");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule